// File: doc/BRIEF.md
# Wide register write collector

This block sits between a narrow host slave interface (32-bit or 64-bit accesses) and an internal register file whose ordinary control registers are 128 bits wide and whose descriptor table entries are 64 bits wide. Narrow host writes are gathered in a holding buffer. The assembled word reaches the register file as a single one-cycle commit strobe, and only when the highest piece of the word arrives. This makes every wide register update atomic from the register file's point of view.

Reads work the other way round. A read of the lowest dword of a word fetches the whole word from the register file, which answers one cycle later, and stores it in a read shadow. Reads of the other pieces are served from that shadow, so the host sees one consistent snapshot. A few dword-wide doorbell registers skip the collector entirely and take effect at once, even in the middle of a pending collection. The address space is split into pages of 0x2000 bytes with the same layout in every page. The top address bit selects the descriptor table region.

Top module: `wide_reg_collector`

## Requirements
- R1: A 128-bit register written as 32-bit dwords at byte offsets 0, 4, 8 and 12 (dword k lands in bits 32k+31:32k) produces no commit for the first three pieces. Exactly one commit follows one cycle after the offset-12 write, carrying the 16-byte aligned address and all four dwords.
- R2: A 128-bit register written as two 64-bit accesses commits one cycle after the access at offset 8. The offset-0 qword lands in bits 63:0 and the offset-8 qword lands in bits 127:64.
- R3: After reset or after a commit, dword slots that were not written in the current collection commit as zero. A lower piece aimed at a different 16-byte word than the pending one discards the pending pieces and starts a new collection.
- R4: A final piece whose 16-byte address differs from the pending collection's address produces no commit, discards the pending pieces and sets seq_err. seq_err stays high until reset.
- R5: A 32-bit write whose in-page offset is 0xC00, 0xC10 or 0xC20 (outside the table region) is a doorbell. One cycle later it raises db_valid with the full address and data, and it produces no commit.
- R6: A doorbell write arriving between the pieces of a pending 128-bit collection leaves that collection intact, and the collection still commits the correct word.
- R7: Page number is h_addr[18:13]. Doorbell decode ignores the page bits, while collection and commit use the full address, so pages are independent.
- R8: Addresses with h_addr[19]=1 are 64-bit table entries. A 32-bit write at entry offset 0 is held. The write at offset 4 commits {offset-4 dword, offset-0 dword} in cm_data[63:0] with cm_tbl=1 and cm_data[127:64]=0. A 64-bit table write commits at once.
- R9: A read at word offset 0 raises rf_rd_req in the same cycle with the aligned word address. One cycle later h_rvalid returns the addressed slice of the fetched word, and the word is kept in the read shadow.
- R10: Reads at other offsets raise no rf_rd_req and return the matching shadow slice one cycle later. 32-bit reads are zero-extended, and a 64-bit read at offset 8 returns shadow bits 127:64.
- R11: Reset clears the shadow and all strobes, so a non-zero-offset read before any fetch returns zero. The shadow is not refreshed by register file changes until the next offset-0 read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_valid | input | 1 | Host access this cycle |
| h_write | input | 1 | 1 = write, 0 = read |
| h_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| h_addr | input | 20 | Byte address |
| h_wdata | input | 64 | Write data (32-bit writes use bits 31:0) |
| h_rvalid | output | 1 | Read response valid |
| h_rdata | output | 64 | Read response data |
| rf_rd_req | output | 1 | Register file fetch request |
| rf_rd_addr | output | 20 | Aligned fetch address |
| rf_rd_data | input | 128 | Fetched word, valid one cycle after the request |
| cm_valid | output | 1 | One-cycle commit strobe |
| cm_tbl | output | 1 | Commit targets a 64-bit table entry |
| cm_addr | output | 20 | Aligned commit address |
| cm_data | output | 128 | Committed word |
| db_valid | output | 1 | One-cycle doorbell strobe |
| db_addr | output | 20 | Doorbell address |
| db_data | output | 32 | Doorbell data |
| seq_err | output | 1 | Sticky collection address mismatch flag |

## Verification
The assertions assume the host issues at most one access per cycle and aligns it to its size. This means addr[1:0] is zero for 32-bit accesses and addr[2:0] is zero for 64-bit accesses. They also assume the register file always answers a fetch on the following cycle. The directed stimulus only ever issues aligned addresses, leaves idle cycles between accesses, and models the register file as a registered pattern generator that follows rf_rd_req by exactly one cycle. Under these conditions the strobe, alignment and read-response properties are meaningful.

// File: rtl/wrc_pkg.sv
// Shared widths and types for the wide register write collector.
// Assumes little-endian packing: dword k occupies bits 32k+31:32k.
package wrc_pkg;
    localparam int DWORD_W = 32;
    localparam int QWORD_W = 64;
    localparam int OWORD_W = 128;
    localparam int LOW_W   = OWORD_W - DWORD_W;   // bits held before the last dword

    typedef logic [DWORD_W-1:0] dword_t;
    typedef logic [QWORD_W-1:0] qword_t;
    typedef logic [OWORD_W-1:0] oword_t;
endpackage

// File: rtl/wrc_decode.sv
// Address classifier. It flags table-region accesses (top address bit)
// and doorbell accesses (32-bit writes to one of the listed in-page offsets).
// Assumes the page size is a power of two given by PAGE_BITS.
module wrc_decode #(
    parameter int ADDR_W    = 20,
    parameter int PAGE_BITS = 13,
    parameter int NUM_DB    = 3,
    parameter logic [NUM_DB-1:0][PAGE_BITS-1:0] DB_OFS = {13'h0C20, 13'h0C10, 13'h0C00}
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wide,
    output logic              is_tbl,
    output logic              is_db
);
    logic [NUM_DB-1:0] hit;

    // One comparator per doorbell offset; the page bits are ignored.
    for (genvar g = 0; g < NUM_DB; g++) begin : g_db
        assign hit[g] = (addr[PAGE_BITS-1:0] == DB_OFS[g]);
    end

    // Region and doorbell classification.
    always_comb begin
        is_tbl = addr[ADDR_W-1];
        is_db  = !is_tbl && !wide && (|hit);
    end
endmodule

// File: rtl/wrc_collector.sv
// Write collector. It holds the lower pieces of a 128-bit register or a
// 64-bit table entry and emits a registered commit strobe when the final
// piece arrives. A final piece to a different address than the pending one
// drops the collection and sets a sticky error. Assumes aligned accesses.
module wrc_collector
    import wrc_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              is_tbl,
    input  logic              wide,
    input  logic [ADDR_W-1:0] addr,
    input  qword_t            wdata,
    output logic              cm_valid,
    output logic              cm_tbl,
    output logic [ADDR_W-1:0] cm_addr,
    output oword_t            cm_data,
    output logic              seq_err
);
    logic [2:0]        r_vld, n_r_vld;
    logic [ADDR_W-1:0] r_base, n_r_base;
    logic [LOW_W-1:0]  r_hold, n_r_hold;
    logic              t_vld, n_t_vld;
    logic [ADDR_W-1:0] t_base, n_t_base;
    dword_t            t_hold, n_t_hold;

    logic              c_v, c_tbl, e_set;
    logic [ADDR_W-1:0] c_addr;
    oword_t            c_data;

    logic [ADDR_W-1:0] reg_base, tbl_base;
    logic              r_final, r_clash;
    logic [LOW_W-1:0]  lowbuf;
    logic [2:0]        vbuf;

    assign reg_base = {addr[ADDR_W-1:4], 4'b0000};
    assign tbl_base = {addr[ADDR_W-1:3], 3'b000};

    // Next-state and commit decision for both collector entries.
    always_comb begin
        n_r_vld  = r_vld;   n_r_base = r_base;  n_r_hold = r_hold;
        n_t_vld  = t_vld;   n_t_base = t_base;  n_t_hold = t_hold;
        c_v = 1'b0; c_tbl = 1'b0; c_addr = '0; c_data = '0; e_set = 1'b0;
        r_final = wide ? addr[3] : (addr[3:2] == 2'd3);
        r_clash = (|r_vld) && (reg_base != r_base);
        lowbuf  = r_clash ? '0 : r_hold;
        vbuf    = r_clash ? 3'b000 : r_vld;
        if (wr_en && !is_tbl) begin
            if (r_final) begin
                if (r_clash) begin
                    e_set = 1'b1;
                end else begin
                    c_v    = 1'b1;
                    c_addr = reg_base;
                    c_data = wide ? {wdata, r_hold[QWORD_W-1:0]} : {wdata[DWORD_W-1:0], r_hold};
                end
                n_r_vld  = '0;
                n_r_hold = '0;
            end else begin
                if (wide) begin
                    lowbuf[QWORD_W-1:0] = wdata;
                    vbuf[1:0] = 2'b11;
                end else begin
                    case (addr[3:2])
                        2'd0:    begin lowbuf[31:0]  = wdata[31:0]; vbuf[0] = 1'b1; end
                        2'd1:    begin lowbuf[63:32] = wdata[31:0]; vbuf[1] = 1'b1; end
                        default: begin lowbuf[95:64] = wdata[31:0]; vbuf[2] = 1'b1; end
                    endcase
                end
                n_r_hold = lowbuf;
                n_r_vld  = vbuf;
                n_r_base = reg_base;
            end
        end else if (wr_en) begin
            if (wide) begin
                c_v = 1'b1; c_tbl = 1'b1; c_addr = tbl_base;
                c_data = {{QWORD_W{1'b0}}, wdata};
            end else if (!addr[2]) begin
                n_t_hold = wdata[DWORD_W-1:0];
                n_t_vld  = 1'b1;
                n_t_base = tbl_base;
            end else begin
                if (t_vld && (tbl_base != t_base)) begin
                    e_set = 1'b1;
                end else begin
                    c_v = 1'b1; c_tbl = 1'b1; c_addr = tbl_base;
                    c_data = {{QWORD_W{1'b0}}, wdata[DWORD_W-1:0], t_hold};
                end
                n_t_vld  = 1'b0;
                n_t_hold = '0;
            end
        end
    end

    // Collector state, sticky error and registered commit strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_vld <= '0; r_base <= '0; r_hold <= '0;
            t_vld <= 1'b0; t_base <= '0; t_hold <= '0;
            cm_valid <= 1'b0; cm_tbl <= 1'b0; cm_addr <= '0; cm_data <= '0;
            seq_err <= 1'b0;
        end else begin
            r_vld <= n_r_vld; r_base <= n_r_base; r_hold <= n_r_hold;
            t_vld <= n_t_vld; t_base <= n_t_base; t_hold <= n_t_hold;
            cm_valid <= c_v; cm_tbl <= c_tbl; cm_addr <= c_addr; cm_data <= c_data;
            if (e_set) seq_err <= 1'b1;
        end
    end
endmodule

// File: rtl/wrc_shadow.sv
// Read path. An offset-0 read fetches the whole word from the register file
// (fixed one-cycle latency) and keeps it in the shadow. Other offsets are
// answered from the shadow. The response is valid one cycle after the request.
module wrc_shadow
    import wrc_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              is_tbl,
    input  logic              wide,
    input  logic [ADDR_W-1:0] addr,
    output logic              rf_rd_req,
    output logic [ADDR_W-1:0] rf_rd_addr,
    input  oword_t            rf_rd_data,
    output logic              h_rvalid,
    output qword_t            h_rdata
);
    oword_t     shadow;
    logic       resp_v, resp_fetch, resp_wide;
    logic [1:0] resp_sel;
    oword_t     src;
    logic       at_base;

    // Fetch request for word-offset-0 reads.
    always_comb begin
        at_base    = is_tbl ? (addr[2:0] == 3'd0) : (addr[3:0] == 4'd0);
        rf_rd_req  = rd_en && at_base;
        rf_rd_addr = is_tbl ? {addr[ADDR_W-1:3], 3'b000} : {addr[ADDR_W-1:4], 4'b0000};
    end

    // Track the outstanding response and refresh the shadow on fetch return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_v <= 1'b0; resp_fetch <= 1'b0; resp_wide <= 1'b0; resp_sel <= '0;
            shadow <= '0;
        end else begin
            resp_v     <= rd_en;
            resp_fetch <= rf_rd_req;
            resp_wide  <= wide;
            resp_sel   <= is_tbl ? {1'b0, addr[2]} : addr[3:2];
            if (resp_fetch) shadow <= rf_rd_data;
        end
    end

    // Select the returned slice from the fresh fetch or the shadow.
    always_comb begin
        src      = resp_fetch ? rf_rd_data : shadow;
        h_rvalid = resp_v;
        if (resp_wide)
            h_rdata = resp_sel[1] ? src[127:64] : src[63:0];
        else
            h_rdata = {{DWORD_W{1'b0}}, src[resp_sel*DWORD_W +: DWORD_W]};
    end
endmodule

// File: rtl/wide_reg_collector.sv
// Top level. It splits host accesses into doorbell writes (immediate strobe),
// collected writes and shadowed reads. Assumes one aligned access per cycle.
module wide_reg_collector
    import wrc_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int PAGE_BITS = 13,
    parameter int NUM_DB    = 3,
    parameter logic [NUM_DB-1:0][PAGE_BITS-1:0] DB_OFS = {13'h0C20, 13'h0C10, 13'h0C00}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_valid,
    input  logic              h_write,
    input  logic              h_wide,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [63:0]       h_wdata,
    output logic              h_rvalid,
    output logic [63:0]       h_rdata,
    output logic              rf_rd_req,
    output logic [ADDR_W-1:0] rf_rd_addr,
    input  logic [127:0]      rf_rd_data,
    output logic              cm_valid,
    output logic              cm_tbl,
    output logic [ADDR_W-1:0] cm_addr,
    output logic [127:0]      cm_data,
    output logic              db_valid,
    output logic [ADDR_W-1:0] db_addr,
    output logic [31:0]       db_data,
    output logic              seq_err
);
    logic is_tbl, is_db, wr_col, rd_en;

    wrc_decode #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .NUM_DB(NUM_DB), .DB_OFS(DB_OFS)) u_dec (
        .addr(h_addr), .wide(h_wide), .is_tbl(is_tbl), .is_db(is_db)
    );

    // Route the access to the doorbell, collector or read path.
    always_comb begin
        wr_col = h_valid && h_write && !is_db;
        rd_en  = h_valid && !h_write;
    end

    // Doorbell strobe, registered one cycle after the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            db_valid <= 1'b0; db_addr <= '0; db_data <= '0;
        end else begin
            db_valid <= h_valid && h_write && is_db;
            db_addr  <= h_addr;
            db_data  <= h_wdata[31:0];
        end
    end

    wrc_collector #(.ADDR_W(ADDR_W)) u_col (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_col), .is_tbl(is_tbl), .wide(h_wide),
        .addr(h_addr), .wdata(h_wdata), .cm_valid(cm_valid), .cm_tbl(cm_tbl),
        .cm_addr(cm_addr), .cm_data(cm_data), .seq_err(seq_err)
    );

    wrc_shadow #(.ADDR_W(ADDR_W)) u_shd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .is_tbl(is_tbl), .wide(h_wide),
        .addr(h_addr), .rf_rd_req(rf_rd_req), .rf_rd_addr(rf_rd_addr),
        .rf_rd_data(rf_rd_data), .h_rvalid(h_rvalid), .h_rdata(h_rdata)
    );
endmodule

// File: rtl/wrc_checker.sv
// Assertion checker for wide_reg_collector, attached by bind below.
// Assumes one aligned host access per cycle.
module wrc_checker #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              h_valid,
    input logic              h_write,
    input logic              h_wide,
    input logic [63:0]       h_wdata,
    input logic              h_rvalid,
    input logic              rf_rd_req,
    input logic [ADDR_W-1:0] rf_rd_addr,
    input logic              cm_valid,
    input logic              cm_tbl,
    input logic [ADDR_W-1:0] cm_addr,
    input logic [127:0]      cm_data,
    input logic              db_valid,
    input logic [31:0]       db_data,
    input logic              seq_err
);
    a_r1_commit_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        cm_valid |-> $past(h_valid && h_write));

    a_r1_reg_commit_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_valid && !cm_tbl) |-> (cm_addr[3:0] == 4'd0));

    a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> seq_err);

    a_r5_db_data: assert property (@(posedge clk) disable iff (!rst_n)
        db_valid |-> ($past(h_valid && h_write && !h_wide) && db_data == $past(h_wdata[31:0])));

    a_r6_db_commit_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cm_valid, db_valid}));

    a_r8_tbl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_valid && cm_tbl) |-> (cm_data[127:64] == 64'd0));

    a_r9_resp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        h_rvalid |-> $past(h_valid && !h_write));

    a_r10_fetch_on_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rd_req |-> (h_valid && !h_write && rf_rd_addr[2:0] == 3'd0));
endmodule

bind wide_reg_collector wrc_checker #(.ADDR_W(ADDR_W)) u_wrc_chk (
    .clk(clk), .rst_n(rst_n), .h_valid(h_valid), .h_write(h_write), .h_wide(h_wide),
    .h_wdata(h_wdata), .h_rvalid(h_rvalid), .rf_rd_req(rf_rd_req), .rf_rd_addr(rf_rd_addr),
    .cm_valid(cm_valid), .cm_tbl(cm_tbl), .cm_addr(cm_addr), .cm_data(cm_data),
    .db_valid(db_valid), .db_data(db_data), .seq_err(seq_err)
);

// File: tb/wide_reg_collector_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module wide_reg_collector_tb_top;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          h_valid = 1'b0, h_write = 1'b0, h_wide = 1'b0;
    logic [AW-1:0] h_addr = '0;
    logic [63:0]   h_wdata = '0;
    logic          h_rvalid, rf_rd_req, cm_valid, cm_tbl, db_valid, seq_err;
    logic [63:0]   h_rdata;
    logic [AW-1:0] rf_rd_addr, cm_addr, db_addr;
    logic [127:0]  rf_rd_data = '0, cm_data;
    logic [31:0]   db_data;
    logic [31:0]   salt = 32'h0;

    int n_chk = 0, n_fail = 0;

    // Values seen at the sampling point after each access.
    logic          s_cm_v, s_cm_tbl, s_db_v, s_rreq, s_rv;
    logic [AW-1:0] s_cm_addr, s_db_addr, s_raddr;
    logic [127:0]  s_cm_data;
    logic [31:0]   s_db_data;
    logic [63:0]   s_rdata;

    always #10 clk = ~clk;   // 50 MHz

    wide_reg_collector dut_i (
        .clk(clk), .rst_n(rst_n), .h_valid(h_valid), .h_write(h_write), .h_wide(h_wide),
        .h_addr(h_addr), .h_wdata(h_wdata), .h_rvalid(h_rvalid), .h_rdata(h_rdata),
        .rf_rd_req(rf_rd_req), .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data),
        .cm_valid(cm_valid), .cm_tbl(cm_tbl), .cm_addr(cm_addr), .cm_data(cm_data),
        .db_valid(db_valid), .db_addr(db_addr), .db_data(db_data), .seq_err(seq_err)
    );

    function automatic logic [127:0] pat(input logic [AW-1:0] a, input logic [31:0] s);
        logic [127:0] w;
        for (int k = 0; k < 4; k++)
            w[k*32 +: 32] = {12'h0, a} ^ (32'h0101_0101 * (k + 1)) ^ s;
        return w;
    endfunction

    // Register file model: answers a fetch one cycle later.
    always @(posedge clk) rf_rd_data <= rf_rd_req ? pat(rf_rd_addr, salt) : 128'h0;

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_wr(input logic [AW-1:0] a, input logic wide, input logic [63:0] d);
        h_valid = 1'b1; h_write = 1'b1; h_wide = wide; h_addr = a; h_wdata = d;
        @(negedge clk);
        s_cm_v = cm_valid; s_cm_tbl = cm_tbl; s_cm_addr = cm_addr; s_cm_data = cm_data;
        s_db_v = db_valid; s_db_addr = db_addr; s_db_data = db_data;
        h_valid = 1'b0; h_write = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_rd(input logic [AW-1:0] a, input logic wide);
        h_valid = 1'b1; h_write = 1'b0; h_wide = wide; h_addr = a;
        #1;
        s_rreq = rf_rd_req; s_raddr = rf_rd_addr;
        @(negedge clk);
        s_rv = h_rvalid; s_rdata = h_rdata;
        h_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R11 cm_valid after reset", 128'(cm_valid), 128'd0);
        chk("R11 db_valid after reset", 128'(db_valid), 128'd0);
        chk("R11 seq_err after reset", 128'(seq_err), 128'd0);
        chk("R11 h_rvalid after reset", 128'(h_rvalid), 128'd0);
        do_rd(20'h00044, 1'b0);
        chk("R11 no fetch at offset 4", 128'(s_rreq), 128'd0);
        chk("R11 empty shadow read", {63'd0, s_rv, s_rdata}, {63'd0, 1'b1, 64'd0});
    endtask

    task automatic t_dword_write();
        do_reset();
        do_wr(20'h00040, 1'b0, 64'h1111_1111);
        chk("R1 no commit dw0", 128'(s_cm_v), 128'd0);
        do_wr(20'h00044, 1'b0, 64'h2222_2222);
        do_wr(20'h00048, 1'b0, 64'h3333_3333);
        chk("R1 no commit dw2", 128'(s_cm_v), 128'd0);
        do_wr(20'h0004C, 1'b0, 64'h4444_4444);
        chk("R1 commit strobe", {126'd0, s_cm_v, s_cm_tbl}, {126'd0, 1'b1, 1'b0});
        chk("R1 commit addr", 128'(s_cm_addr), 128'h40);
        chk("R1 commit data", s_cm_data, 128'h4444_4444_3333_3333_2222_2222_1111_1111);
    endtask

    task automatic t_qword_write_paged();
        do_reset();
        do_wr(20'h06080, 1'b1, 64'hAAAA_0001_BBBB_0002);
        chk("R2 no commit low qword", 128'(s_cm_v), 128'd0);
        do_wr(20'h06088, 1'b1, 64'hCCCC_0003_DDDD_0004);
        chk("R2 commit strobe", 128'(s_cm_v), 128'd1);
        chk("R7 paged commit addr", 128'(s_cm_addr), 128'h6080);
        chk("R2 commit data", s_cm_data, 128'hCCCC_0003_DDDD_0004_AAAA_0001_BBBB_0002);
    endtask

    task automatic t_zero_fill_restart();
        do_reset();
        do_wr(20'h0010C, 1'b0, 64'h5);
        chk("R3 lone final commit", {s_cm_v, s_cm_data}, {1'b1, 128'h0000_0005_0000_0000_0000_0000_0000_0000});
        do_wr(20'h00200, 1'b0, 64'h1);
        do_wr(20'h00300, 1'b0, 64'h2);
        do_wr(20'h00304, 1'b0, 64'h3);
        do_wr(20'h0030C, 1'b0, 64'h4);
        chk("R3 restart commit addr", 128'(s_cm_addr), 128'h300);
        chk("R3 restart commit data", s_cm_data, 128'h0000_0004_0000_0000_0000_0003_0000_0002);
        chk("R3 no error on restart", 128'(seq_err), 128'd0);
    endtask

    task automatic t_mismatch();
        do_reset();
        do_wr(20'h00400, 1'b0, 64'h9);
        do_wr(20'h0050C, 1'b0, 64'h7);
        chk("R4 no commit on mismatch", 128'(s_cm_v), 128'd0);
        chk("R4 error set", 128'(seq_err), 128'd1);
        do_wr(20'h0050C, 1'b0, 64'h7);
        chk("R4 pending dropped", {s_cm_v, s_cm_data}, {1'b1, 128'h0000_0007_0000_0000_0000_0000_0000_0000});
        chk("R4 error sticky", 128'(seq_err), 128'd1);
    endtask

    task automatic t_doorbell();
        do_reset();
        do_wr(20'h04C10, 1'b0, 64'hDEAD_BEEF);
        chk("R5 doorbell strobe", {s_db_v, s_cm_v}, {1'b1, 1'b0});
        chk("R7 doorbell paged addr", 128'(s_db_addr), 128'h4C10);
        chk("R5 doorbell data", 128'(s_db_data), 128'hDEAD_BEEF);
    endtask

    task automatic t_doorbell_mid_collect();
        do_reset();
        do_wr(20'h00040, 1'b0, 64'h1);
        do_wr(20'h00044, 1'b0, 64'h2);
        do_wr(20'h00C00, 1'b0, 64'h77);
        chk("R6 doorbell mid collection", {s_db_v, s_cm_v, 32'(s_db_data)}, {1'b1, 1'b0, 32'h77});
        do_wr(20'h00048, 1'b0, 64'h3);
        do_wr(20'h0004C, 1'b0, 64'h4);
        chk("R6 collection intact", {s_cm_v, s_cm_data}, {1'b1, 128'h0000_0004_0000_0003_0000_0002_0000_0001});
        chk("R6 no error", 128'(seq_err), 128'd0);
    endtask

    task automatic t_table();
        do_reset();
        do_wr(20'h80010, 1'b0, 64'h1234);
        chk("R8 table low held", 128'(s_cm_v), 128'd0);
        do_wr(20'h80014, 1'b0, 64'h5678);
        chk("R8 table commit", {s_cm_v, s_cm_tbl, 20'(s_cm_addr)}, {1'b1, 1'b1, 20'h80010});
        chk("R8 table data", s_cm_data, 128'h0000_5678_0000_1234);
        do_wr(20'h80018, 1'b1, 64'h0123_4567_89AB_CDEF);
        chk("R8 wide table commit", {s_cm_v, s_cm_data}, {1'b1, 128'h0123_4567_89AB_CDEF});
    endtask

    task automatic t_reads();
        logic [127:0] w0;
        do_reset();
        salt = 32'h0;
        w0 = pat(20'h00040, 32'h0);
        do_rd(20'h00040, 1'b0);
        chk("R9 fetch request", {s_rreq, 20'(s_raddr)}, {1'b1, 20'h00040});
        chk("R9 fetched dword0", {s_rv, s_rdata}, {1'b1, 32'd0, w0[31:0]});
        do_rd(20'h00044, 1'b0);
        chk("R10 no fetch at 4", 128'(s_rreq), 128'd0);
        chk("R10 shadow dword1", 128'(s_rdata), {96'd0, w0[63:32]});
        do_rd(20'h0004C, 1'b0);
        chk("R10 shadow dword3", 128'(s_rdata), {96'd0, w0[127:96]});
        do_rd(20'h00048, 1'b1);
        chk("R10 shadow upper qword", 128'(s_rdata), {64'd0, w0[127:64]});
        salt = 32'hFFFF_0000;
        do_rd(20'h00048, 1'b0);
        chk("R11 stale shadow kept", 128'(s_rdata), {96'd0, w0[95:64]});
        do_rd(20'h00040, 1'b1);
        chk("R9 refetch wide", 128'(s_rdata), {64'd0, pat(20'h00040, salt)[63:0]});
        do_rd(20'h80008, 1'b0);
        chk("R9 table fetch addr", {s_rreq, 20'(s_raddr)}, {1'b1, 20'h80008});
        do_rd(20'h8000C, 1'b0);
        chk("R10 table upper dword", 128'(s_rdata), {96'd0, pat(20'h80008, salt)[63:32]});
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_dword_write();
        t_qword_write_paged();
        t_zero_fill_restart();
        t_mismatch();
        t_doorbell();
        t_doorbell_mid_collect();
        t_table();
        t_reads();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule